// File: doc/BRIEF.md
# Automatic RTS Receive Flow Controller

This block drives the active-low request-to-send line of a serial receiver from the fill level of its receive FIFO. When the FIFO fills up to a high-water mark, the block raises the pin so the remote sender pauses. When the FIFO drains to a low-water mark, the block drops the pin again. Between the two marks the pin keeps its last value, so it does not toggle on every byte. Each trigger setting has its own pair of marks, and an elaboration parameter picks the table for either a 16-deep or a 64-deep FIFO.

The block also raises a receive-data-ready flag whenever the FIFO count is at or above the selected trigger level. A sticky interrupt flag records every rising edge of the pin while automatic mode and its interrupt enable are both on. Without automatic mode, or when the host withdraws its request, the pin simply mirrors the inverted host request bit.

Top module: `rts_flow_ctl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rts_n` is 1 and both `rts_irq` and `rx_rdy_irq` (with an empty FIFO) are 0.
- R2: When automatic mode is not active (`auto_en`=0 or `rts_req`=0), `rts_n` takes the value of `~rts_req` at the next clock edge, whatever the FIFO count is.
- R3: In automatic mode (`auto_en`=1 and `rts_req`=1), a count at or above the high mark sets `rts_n` to 1 at the next edge. For `trig_sel` 0,1,2,3 the high marks are 16,56,60,60 with 64-deep tables and 2,8,14,14 with 16-deep tables.
- R4: In automatic mode, a count at or below the low mark clears `rts_n` to 0 at the next edge. For `trig_sel` 0,1,2,3 the low marks are 0,8,16,56 with 64-deep tables and 0,1,4,8 with 16-deep tables.
- R5: In automatic mode, a count strictly between the low and high marks leaves `rts_n` unchanged.
- R6: `rx_rdy_irq` is 1 in the same cycle whenever `rx_count` is at or above the trigger level. For `trig_sel` 0,1,2,3 the levels are 8,16,56,60 with 64-deep tables and 1,4,8,14 with 16-deep tables.
- R7: On the edge where `rts_n` goes from 0 to 1, `rts_irq` becomes 1 if `auto_en` and `rts_ie` were both 1 in the cycle before that edge.
- R8: Once set, `rts_irq` stays 1 until `rts_irq_clr` is high at an edge. If a new qualifying rise happens at that same edge, the flag stays set.
- R9: `rts_irq` is never set by a rise of `rts_n` that happens while `rts_ie` or `auto_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | CW (7 or 5) | Current receive FIFO fill count |
| trig_sel | input | 2 | Trigger and threshold select |
| auto_en | input | 1 | Automatic RTS enable |
| rts_req | input | 1 | Host request-to-send bit |
| rts_ie | input | 1 | RTS-transition interrupt enable |
| rts_irq_clr | input | 1 | Host clear pulse for `rts_irq` |
| rts_n | output | 1 | Active-low RTS pin |
| rx_rdy_irq | output | 1 | Receive-data-ready flag |
| rts_irq | output | 1 | Sticky RTS rising-edge interrupt flag |

## Verification
Two events can meet at a single clock edge: the host clearing the sticky interrupt, and a fresh rise of the pin that sets it again. The bench first brings the pin low in automatic mode. It then applies a count at the high mark and, in that same cycle, pulses the clear while the flag is already set. After the edge it expects the pin high and the flag still set, because setting takes priority over clearing. The bench also checks the clear when it is applied on its own, and checks that a rise with the interrupt enable off, or with automatic mode off, leaves the flag at 0.

// File: rtl/rts_flow_ctl.sv
module rts_flow_ctl #(
  parameter bit DEEP64 = 1'b1,
  localparam int CW = DEEP64 ? 7 : 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [1:0]    trig_sel,
  input  logic          auto_en,
  input  logic          rts_req,
  input  logic          rts_ie,
  input  logic          rts_irq_clr,
  output logic          rts_n,
  output logic          rx_rdy_irq,
  output logic          rts_irq
);

  logic [CW-1:0] trig_lvl, hi_lvl, lo_lvl;
  logic          auto_act, rts_n_nxt, rise;

  if (DEEP64) begin : g_t64
    always_comb begin
      unique case (trig_sel)
        2'd0: begin trig_lvl = CW'(8);  hi_lvl = CW'(16); lo_lvl = CW'(0);  end
        2'd1: begin trig_lvl = CW'(16); hi_lvl = CW'(56); lo_lvl = CW'(8);  end
        2'd2: begin trig_lvl = CW'(56); hi_lvl = CW'(60); lo_lvl = CW'(16); end
        default: begin trig_lvl = CW'(60); hi_lvl = CW'(60); lo_lvl = CW'(56); end
      endcase
    end
  end else begin : g_t16
    always_comb begin
      unique case (trig_sel)
        2'd0: begin trig_lvl = CW'(1);  hi_lvl = CW'(2);  lo_lvl = CW'(0); end
        2'd1: begin trig_lvl = CW'(4);  hi_lvl = CW'(8);  lo_lvl = CW'(1); end
        2'd2: begin trig_lvl = CW'(8);  hi_lvl = CW'(14); lo_lvl = CW'(4); end
        default: begin trig_lvl = CW'(14); hi_lvl = CW'(14); lo_lvl = CW'(8); end
      endcase
    end
  end

  assign auto_act   = auto_en & rts_req;
  assign rx_rdy_irq = rx_count >= trig_lvl;

  always_comb begin
    if (!auto_act)                rts_n_nxt = ~rts_req;
    else if (rx_count >= hi_lvl)  rts_n_nxt = 1'b1;
    else if (rx_count <= lo_lvl)  rts_n_nxt = 1'b0;
    else                          rts_n_nxt = rts_n;
  end

  assign rise = ~rts_n & rts_n_nxt & auto_en & rts_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n   <= 1'b1;
      rts_irq <= 1'b0;
    end else begin
      rts_n <= rts_n_nxt;
      if (rise)             rts_irq <= 1'b1;
      else if (rts_irq_clr) rts_irq <= 1'b0;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) !rst_n |=> (rts_n && !rts_irq));

  a_r2_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_act |=> (rts_n == !$past(rts_req)));

  a_r3_pause_high: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && rx_count >= hi_lvl) |=> rts_n);

  a_r4_resume_low: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && rx_count <= lo_lvl) |=> !rts_n);

  a_r5_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_act && rx_count > lo_lvl && rx_count < hi_lvl) |=> $stable(rts_n));

  a_r7_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_n) && $past(auto_en && rts_ie)) |-> rts_irq);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_irq && !rts_irq_clr) |=> rts_irq);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_irq) |-> ($rose(rts_n) && $past(auto_en && rts_ie)));

endmodule

// File: tb/rts_flow_ctl_tb.sv
module rts_flow_ctl_tb;
  localparam int CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] rx_count = '0;
  logic [1:0]    trig_sel = '0;
  logic          auto_en = 1'b0, rts_req = 1'b0, rts_ie = 1'b0, rts_irq_clr = 1'b0;
  logic          rts_n, rx_rdy_irq, rts_irq;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rts_flow_ctl #(.DEEP64(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .trig_sel(trig_sel),
    .auto_en(auto_en), .rts_req(rts_req), .rts_ie(rts_ie),
    .rts_irq_clr(rts_irq_clr), .rts_n(rts_n), .rx_rdy_irq(rx_rdy_irq),
    .rts_irq(rts_irq)
  );

  function automatic int trig_of(int s);
    case (s) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
  endfunction
  function automatic int hi_of(int s);
    case (s) 0: return 16; 1: return 56; 2: return 60; default: return 60; endcase
  endfunction
  function automatic int lo_of(int s);
    case (s) 0: return 0; 1: return 8; 2: return 16; default: return 56; endcase
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    check("R1 rts_n", rts_n, 1);
    check("R1 rts_irq", rts_irq, 0);
    check("R1 rx_rdy_irq", rx_rdy_irq, 0);
    rst_n = 1'b1; tick();
    check("R1 rts_n after release", rts_n, 1);
    check("R1 rts_irq after release", rts_irq, 0);
  endtask

  task automatic t_manual();
    auto_en = 1'b0; rts_req = 1'b1; rx_count = 7'd63; tick();
    check("R2 manual req=1 full fifo", rts_n, 0);
    rts_req = 1'b0; rx_count = 7'd0; tick();
    check("R2 manual req=0 empty fifo", rts_n, 1);
    auto_en = 1'b1; rts_req = 1'b0; tick();
    check("R2 auto but no request", rts_n, 1);
    rts_req = 1'b1; rx_count = 7'd60; tick();
    check("R3 auto on at full count", rts_n, 1);
  endtask

  task automatic t_thresholds();
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s); auto_en = 1'b1; rts_req = 1'b1; rts_ie = 1'b0;
      rx_count = CW'(trig_of(s) - 1); #1;
      check($sformatf("R6 sel%0d below trigger", s), rx_rdy_irq, 0);
      rx_count = CW'(trig_of(s)); #1;
      check($sformatf("R6 sel%0d at trigger", s), rx_rdy_irq, 1);
      rx_count = CW'(lo_of(s)); tick();
      check($sformatf("R4 sel%0d at low mark", s), rts_n, 0);
      rx_count = CW'(hi_of(s) - 1); tick();
      check($sformatf("R5 sel%0d below high mark holds low", s), rts_n, 0);
      rx_count = CW'(hi_of(s)); tick();
      check($sformatf("R3 sel%0d at high mark", s), rts_n, 1);
      rx_count = CW'(lo_of(s) + 1); tick();
      check($sformatf("R5 sel%0d above low mark holds high", s), rts_n, 1);
      rx_count = CW'(lo_of(s)); tick();
      check($sformatf("R4 sel%0d back at low mark", s), rts_n, 0);
    end
    check("R9 no irq with rts_ie=0", rts_irq, 0);
  endtask

  task automatic t_irq();
    trig_sel = 2'd1; auto_en = 1'b1; rts_req = 1'b1; rts_ie = 1'b1;
    rx_count = 7'd0; tick();
    check("R4 pin low before irq test", rts_n, 0);
    check("R9 irq idle", rts_irq, 0);
    rx_count = 7'd56; tick();
    check("R3 pin rises", rts_n, 1);
    check("R7 irq set on rise", rts_irq, 1);
    rx_count = 7'd0; tick(); tick();
    check("R8 irq held after pin falls", rts_irq, 1);
    rts_irq_clr = 1'b1; tick(); rts_irq_clr = 1'b0;
    check("R8 clear works", rts_irq, 0);
    rts_irq_clr = 1'b1; rx_count = 7'd0; tick(); rts_irq_clr = 1'b0;
    rx_count = 7'd56; tick();
    check("R7 second rise sets again", rts_irq, 1);
    rx_count = 7'd0; tick();
    rx_count = 7'd60; rts_irq_clr = 1'b1; tick(); rts_irq_clr = 1'b0;
    check("R8 same-cycle rise and clear pin", rts_n, 1);
    check("R8 same-cycle rise beats clear", rts_irq, 1);
    rts_irq_clr = 1'b1; tick(); rts_irq_clr = 1'b0;
    check("R8 cleared afterwards", rts_irq, 0);
    auto_en = 1'b0; rts_req = 1'b1; tick();
    check("R2 manual low", rts_n, 0);
    rts_req = 1'b0; tick();
    check("R9 manual rise pin", rts_n, 1);
    check("R9 manual rise no irq", rts_irq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #23;
    t_reset();
    t_manual();
    t_thresholds();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule